// File: doc/BRIEF.md
# System Control Register Access Unit

This block holds the system-control registers of a 64-bit processor core and serves the core's move-from and move-to instructions for them. Each instruction has a 32-bit form and a 64-bit form. An access names a register by a 5-bit number and a 3-bit select. On a write, the block shapes the data for the addressed register: it masks bits, merges in old contents, forces fixed bits, or discards the write. On a read, the 32-bit form returns the low word sign-extended to 64 bits. The 64-bit form returns the whole value for the registers that hold addresses.

The pipeline drives one access at a time with `valid_i`. Read data and the two flags are combinational from the access inputs in the same cycle. `ri_o` reports an unsupported register/select pair, which the core turns into a reserved-instruction exception. `stop_o` tells the front end to end the current translation block, because the write may have changed the execution mode. A write takes effect at the rising clock edge. TLB storage, counter increment and timer interrupts belong to neighbouring blocks.

Top module: `sysreg_unit`

## Requirements
- R1: After reset every stored register reads 0, with these exceptions: the vector base (15/1) reads 0xFFFFFFFF80000000, the random pointer (1/0) reads TLB_ENTRIES-1, and the identity (15/0), option 1 (16/1) and option 3 (16/3) read their parameter values sign-extended.
- R2: A read with wide_i=0, and any read of a 32-bit register, returns bits 31:0 sign-extended to 64 bits. A 32-bit write stores the sign extension of wdata_i[31:0] before shaping. The 32-bit registers are counter 9/0, match 11/0, status 12/0, shadow map 12/3, cause 13/0, option 0 16/0, tag/data in register 28, and scratch 31/0.
- R3: With wide_i=1, a read or write of an address register uses all 64 bits. The address registers are translation-low 2/0 and 3/0, context 4/0, fault address 8/0, translation-high 10/0, exception return 14/0 and vector base 15/1.
- R4: Write masks: 2/0 and 3/0 keep bits 29:0 and clear the rest. 10/0 ANDs with 0xFFFFFFFFFFFFE0FF. 12/0 stores the sign extension of (data[31:0] AND 0xFA78FF01).
- R5: A write to context 4/0 keeps stored bits 63:23, loads bits 22:4 from the data, and clears bits 3:0.
- R6: A write to vector base 15/1 stores the sign extension of 0x80000000 OR (data[31:0] AND 0x3FFFF000).
- R7: A tag write ANDs data[31:0] with 0xFFFFFCF6 and then sign-extends it. Every write to shadow map 12/3 stores 0.
- R8: Writes to random pointer 1/0, fault address 8/0, identity 15/0, option 1 16/1 and option 3 16/3 change nothing and raise no flag other than stop_o where R11 calls for it.
- R9: In register 28, selects 0, 2, 4 and 6 reach the tag register and selects 1, 3, 5 and 7 reach the data register.
- R10: Any pair not listed in R1 to R9 raises ri_o in the access cycle. Such an access changes no state, drives rdata_o to 0 and keeps stop_o low. A read (write_i=0) with dst_zero_i=1 is a no-op: ri_o=0 and rdata_o=0.
- R11: stop_o is high in the cycle of a valid write to 9/0, 11/0, any supported pair of register 12, 13/0, any supported pair of register 16, or 31/0. It is low for reads and for every other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access present this cycle |
| write_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| wide_i | input | 1 | 1 = 64-bit form, 0 = 32-bit form |
| dst_zero_i | input | 1 | Destination general register of a read is register 0 |
| reg_i | input | 5 | Register number |
| sel_i | input | 3 | Register select |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data |
| ri_o | output | 1 | Unsupported register/select pair |
| stop_o | output | 1 | Write may change execution mode |

## Verification
Read data, ri_o and stop_o are combinational, so they are due in the access cycle itself. The bench drives each access at the falling edge and samples these outputs one time unit later, before the next rising edge. A write updates storage at the next rising edge. Its effect is therefore checked by a read issued at the following falling edge, and each shaping rule is observed through the read port one cycle after the write. Ignored and rejected writes are checked the same way, by reading back the register that could have been touched.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int XLEN = 64;
  localparam int HLEN = 32;

  typedef enum logic [4:0] {
    ID_RND, ID_XLO0, ID_XLO1, ID_CTX, ID_FADDR, ID_CNT, ID_XHI, ID_MATCH,
    ID_STAT, ID_SMAP, ID_CAUSE, ID_ERET, ID_IDENT, ID_VBASE, ID_OPT0,
    ID_OPT1, ID_OPT3, ID_TAG, ID_DATA, ID_SCR
  } reg_id_e;

  localparam int NUM_ID = 20;

  function automatic logic [XLEN-1:0] sext_w(input logic [HLEN-1:0] v);
    return {{(XLEN-HLEN){v[HLEN-1]}}, v};
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic [4:0] reg_i,
  input  logic [2:0] sel_i,
  output reg_id_e    id_o,
  output logic       hit_o,
  output logic       wide_o,
  output logic       ro_o,
  output logic       stop_o
);
  always_comb begin
    id_o  = ID_RND;
    hit_o = 1'b1;
    unique casez ({reg_i, sel_i})
      {5'd1,  3'd0}: id_o = ID_RND;
      {5'd2,  3'd0}: id_o = ID_XLO0;
      {5'd3,  3'd0}: id_o = ID_XLO1;
      {5'd4,  3'd0}: id_o = ID_CTX;
      {5'd8,  3'd0}: id_o = ID_FADDR;
      {5'd9,  3'd0}: id_o = ID_CNT;
      {5'd10, 3'd0}: id_o = ID_XHI;
      {5'd11, 3'd0}: id_o = ID_MATCH;
      {5'd12, 3'd0}: id_o = ID_STAT;
      {5'd12, 3'd3}: id_o = ID_SMAP;
      {5'd13, 3'd0}: id_o = ID_CAUSE;
      {5'd14, 3'd0}: id_o = ID_ERET;
      {5'd15, 3'd0}: id_o = ID_IDENT;
      {5'd15, 3'd1}: id_o = ID_VBASE;
      {5'd16, 3'd0}: id_o = ID_OPT0;
      {5'd16, 3'd1}: id_o = ID_OPT1;
      {5'd16, 3'd3}: id_o = ID_OPT3;
      {5'd28, 3'b??0}: id_o = ID_TAG;   // even selects: tag
      {5'd28, 3'b??1}: id_o = ID_DATA;  // odd selects: data
      {5'd31, 3'd0}: id_o = ID_SCR;
      default: hit_o = 1'b0;
    endcase
  end

  always_comb begin
    wide_o = id_o inside {ID_XLO0, ID_XLO1, ID_CTX, ID_FADDR, ID_XHI, ID_ERET, ID_VBASE};
    ro_o   = id_o inside {ID_RND, ID_FADDR, ID_IDENT, ID_OPT1, ID_OPT3};
    stop_o = hit_o && (id_o inside {ID_CNT, ID_MATCH, ID_STAT, ID_SMAP, ID_CAUSE,
                                    ID_OPT0, ID_OPT1, ID_OPT3, ID_SCR});
  end
endmodule

// File: rtl/sysreg_wr_shape.sv
module sysreg_wr_shape
  import sysreg_pkg::*;
(
  input  reg_id_e         id_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] old_i,
  output logic [XLEN-1:0] new_o
);
  logic [XLEN-1:0] d;

  always_comb begin
    d = wide_i ? wdata_i : sext_w(wdata_i[HLEN-1:0]);
    unique case (id_i)
      ID_XLO0, ID_XLO1: new_o = d & {{(XLEN-30){1'b0}}, {30{1'b1}}};
      ID_CTX:           new_o = {old_i[XLEN-1:23], d[22:4], 4'b0000};
      ID_XHI:           new_o = d & {{(XLEN-HLEN){1'b1}}, 32'hFFFF_E0FF};
      ID_STAT:          new_o = sext_w(d[HLEN-1:0] & 32'hFA78_FF01);
      ID_SMAP:          new_o = '0;
      ID_VBASE:         new_o = sext_w(32'h8000_0000 | (d[HLEN-1:0] & 32'h3FFF_F000));
      ID_TAG:           new_o = sext_w(d[HLEN-1:0] & 32'hFFFF_FCF6);
      ID_ERET:          new_o = d;
      default:          new_o = sext_w(d[HLEN-1:0]);
    endcase
  end
endmodule

// File: rtl/sysreg_unit.sv
module sysreg_unit
  import sysreg_pkg::*;
#(
  parameter int          TLB_ENTRIES = 16,
  parameter logic [31:0] IDENT_VAL   = 32'h0001_8000,
  parameter logic [31:0] OPT1_VAL    = 32'h9E19_0C8F,
  parameter logic [31:0] OPT3_VAL    = 32'h0000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            write_i,
  input  logic            wide_i,
  input  logic            dst_zero_i,
  input  logic [4:0]      reg_i,
  input  logic [2:0]      sel_i,
  input  logic [63:0]     wdata_i,
  output logic [63:0]     rdata_o,
  output logic            ri_o,
  output logic            stop_o
);
  localparam logic [XLEN-1:0] RND_TOP = XLEN'(TLB_ENTRIES - 1);

  reg_id_e         id;
  logic            hit, wide_reg, ro, stop_reg, wr_en, rd_en;
  logic [XLEN-1:0] rf_q [NUM_ID];
  logic [XLEN-1:0] shaped, cur;

  sysreg_decode u_dec (
    .reg_i (reg_i), .sel_i (sel_i), .id_o (id), .hit_o (hit),
    .wide_o (wide_reg), .ro_o (ro), .stop_o (stop_reg)
  );

  sysreg_wr_shape u_shape (
    .id_i (id), .wide_i (wide_i), .wdata_i (wdata_i),
    .old_i (rf_q[id]), .new_o (shaped)
  );

  assign wr_en  = valid_i && write_i && hit && !ro;
  assign rd_en  = valid_i && !write_i && !dst_zero_i && hit;
  assign ri_o   = valid_i && !hit && (write_i || !dst_zero_i);
  assign stop_o = valid_i && write_i && stop_reg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ID; i++) rf_q[i] <= '0;
      rf_q[ID_VBASE] <= sext_w(32'h8000_0000);
    end else if (wr_en) begin
      rf_q[id] <= shaped;
    end
  end

  always_comb begin
    unique case (id)
      ID_RND:   cur = RND_TOP;
      ID_IDENT: cur = sext_w(IDENT_VAL);
      ID_OPT1:  cur = sext_w(OPT1_VAL);
      ID_OPT3:  cur = sext_w(OPT3_VAL);
      default:  cur = rf_q[id];
    endcase
    if (!rd_en)                rdata_o = '0;
    else if (wide_i && wide_reg) rdata_o = cur;
    else                       rdata_o = sext_w(cur[HLEN-1:0]);
  end

  // R2
  sext_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !write_i && !wide_i) |-> (rdata_o[XLEN-1:HLEN] == {(XLEN-HLEN){rdata_o[HLEN-1]}}));
  // R4
  xlo_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_q[ID_XLO0][XLEN-1:30] == '0) && (rf_q[ID_XLO1][XLEN-1:30] == '0));
  // R5
  ctx_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_q[ID_CTX][3:0] == 4'b0000);
  // R6
  vbase_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_q[ID_VBASE][XLEN-1:31] == '1);
  // R7
  smap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_q[ID_SMAP] == '0);
  // R10
  ri_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_o |-> (!wr_en && !stop_o && rdata_o == '0));
  // R11
  stop_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (valid_i && write_i && hit));
endmodule

// File: tb/sysreg_unit_bench.sv
module sysreg_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDENT = 32'h0001_8000;
  localparam logic [31:0] OPT1  = 32'h9E19_0C8F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, wide = 1'b0, dz = 1'b0;
  logic [4:0]  rg = '0;
  logic [2:0]  sl = '0;
  logic [63:0] wd = '0, rd;
  logic        ri, stop;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_unit u_sysreg_unit (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .write_i (wr), .wide_i (wide),
    .dst_zero_i (dz), .reg_i (rg), .sel_i (sl), .wdata_i (wd),
    .rdata_o (rd), .ri_o (ri), .stop_o (stop)
  );

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_acc(input int r, input int s, input logic w, input logic [63:0] d,
                        output logic ri_s, output logic stop_s);
    @(negedge clk);
    valid = 1'b1; wr = 1'b1; wide = w; dz = 1'b0; rg = 5'(r); sl = 3'(s); wd = d;
    #1; ri_s = ri; stop_s = stop;
    @(posedge clk); #1; valid = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_acc(input int r, input int s, input logic w, input logic z,
                        output logic [63:0] v, output logic ri_s);
    @(negedge clk);
    valid = 1'b1; wr = 1'b0; wide = w; dz = z; rg = 5'(r); sl = 3'(s);
    #1; v = rd; ri_s = ri;
    valid = 1'b0; dz = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] v; logic f;
    rd_acc(15, 0, 1'b0, 1'b0, v, f); chk("R1 ident", v, sx(IDENT));
    rd_acc(16, 1, 1'b1, 1'b0, v, f); chk("R1 opt1", v, sx(OPT1));
    rd_acc(1, 0, 1'b0, 1'b0, v, f);  chk("R1 random", v, 64'd15);
    rd_acc(15, 1, 1'b1, 1'b0, v, f); chk("R1 vbase", v, 64'hFFFF_FFFF_8000_0000);
    rd_acc(2, 0, 1'b1, 1'b0, v, f);  chk("R1 xlo0", v, 64'd0);
    rd_acc(12, 0, 1'b0, 1'b0, v, f); chk("R1 status", v, 64'd0);
  endtask

  task automatic t_width;
    logic [63:0] v; logic f, s;
    wr_acc(14, 0, 1'b1, 64'h1234_5678_9ABC_DEF0, f, s);
    rd_acc(14, 0, 1'b0, 1'b0, v, f); chk("R2 narrow read of eret", v, 64'hFFFF_FFFF_9ABC_DEF0);
    rd_acc(14, 0, 1'b1, 1'b0, v, f); chk("R3 wide read of eret", v, 64'h1234_5678_9ABC_DEF0);
    wr_acc(14, 0, 1'b0, 64'hDEAD_0000_7000_0001, f, s);
    rd_acc(14, 0, 1'b1, 1'b0, v, f); chk("R2 narrow write sext", v, 64'h0000_0000_7000_0001);
    wr_acc(13, 0, 1'b1, 64'hAAAA_BBBB_8000_0002, f, s);
    rd_acc(13, 0, 1'b1, 1'b0, v, f); chk("R2 wide read of cause", v, 64'hFFFF_FFFF_8000_0002);
  endtask

  task automatic t_masks;
    logic [63:0] v; logic f, s;
    wr_acc(2, 0, 1'b1, '1, f, s);
    rd_acc(2, 0, 1'b1, 1'b0, v, f); chk("R4 xlo0", v, 64'h0000_0000_3FFF_FFFF);
    wr_acc(3, 0, 1'b0, 64'h0000_0000_C000_0005, f, s);
    rd_acc(3, 0, 1'b1, 1'b0, v, f); chk("R4 xlo1", v, 64'h5);
    wr_acc(10, 0, 1'b1, '1, f, s);
    rd_acc(10, 0, 1'b1, 1'b0, v, f); chk("R4 xhi", v, 64'hFFFF_FFFF_FFFF_E0FF);
    wr_acc(12, 0, 1'b0, 64'hFFFF_FFFF, f, s);
    chk("R11 stop on status", {63'd0, s}, 64'd1);
    rd_acc(12, 0, 1'b0, 1'b0, v, f); chk("R4 status", v, 64'hFFFF_FFFF_FA78_FF01);
  endtask

  task automatic t_ctx;
    logic [63:0] v; logic f, s;
    wr_acc(4, 0, 1'b1, '1, f, s);
    rd_acc(4, 0, 1'b1, 1'b0, v, f); chk("R5 ctx ones", v, 64'h0000_0000_007F_FFF0);
    wr_acc(4, 0, 1'b1, 64'h1234_5678_9ABC_DEF5, f, s);
    rd_acc(4, 0, 1'b1, 1'b0, v, f); chk("R5 ctx pattern", v, 64'h0000_0000_003C_DEF0);
  endtask

  task automatic t_vbase;
    logic [63:0] v; logic f, s;
    wr_acc(15, 1, 1'b0, 64'hFFFF_FFFF, f, s);
    rd_acc(15, 1, 1'b1, 1'b0, v, f); chk("R6 vbase ones", v, 64'hFFFF_FFFF_BFFF_F000);
    wr_acc(15, 1, 1'b1, 64'h0, f, s);
    rd_acc(15, 1, 1'b1, 1'b0, v, f); chk("R6 vbase zero", v, 64'hFFFF_FFFF_8000_0000);
  endtask

  task automatic t_cache;
    logic [63:0] v; logic f, s;
    wr_acc(28, 2, 1'b0, 64'hFFFF_FFFF, f, s);
    rd_acc(28, 0, 1'b0, 1'b0, v, f); chk("R7 R9 tag mask via sel2", v, 64'hFFFF_FFFF_FFFF_FCF6);
    wr_acc(28, 5, 1'b0, 64'h1234_5678, f, s);
    rd_acc(28, 1, 1'b0, 1'b0, v, f); chk("R9 data via sel5", v, 64'h1234_5678);
    rd_acc(28, 6, 1'b0, 1'b0, v, f); chk("R9 tag intact", v, 64'hFFFF_FFFF_FFFF_FCF6);
    wr_acc(12, 3, 1'b0, 64'hFFFF_FFFF, f, s);
    chk("R11 stop on smap", {63'd0, s}, 64'd1);
    rd_acc(12, 3, 1'b0, 1'b0, v, f); chk("R7 smap zero", v, 64'd0);
  endtask

  task automatic t_ignored;
    logic [63:0] v; logic f, s;
    wr_acc(1, 0, 1'b0, 64'h0, f, s);
    chk("R8 random no ri", {63'd0, f}, 64'd0);
    rd_acc(1, 0, 1'b0, 1'b0, v, f); chk("R8 random", v, 64'd15);
    wr_acc(15, 0, 1'b0, 64'h55, f, s);
    rd_acc(15, 0, 1'b0, 1'b0, v, f); chk("R8 ident", v, sx(IDENT));
    wr_acc(16, 1, 1'b0, 64'h0, f, s);
    chk("R8 R11 opt1 stop", {63'd0, s}, 64'd1);
    rd_acc(16, 1, 1'b0, 1'b0, v, f); chk("R8 opt1", v, sx(OPT1));
    wr_acc(8, 0, 1'b1, 64'hFF, f, s);
    rd_acc(8, 0, 1'b1, 1'b0, v, f); chk("R8 faddr", v, 64'd0);
  endtask

  task automatic t_reserved;
    logic [63:0] v; logic f, s;
    rd_acc(5, 0, 1'b0, 1'b0, v, f);
    chk("R10 ri read 5/0", {63'd0, f}, 64'd1); chk("R10 rdata 0", v, 64'd0);
    rd_acc(15, 2, 1'b1, 1'b0, v, f); chk("R10 ri read 15/2", {63'd0, f}, 64'd1);
    wr_acc(3, 1, 1'b1, '1, f, s);
    chk("R10 ri write 3/1", {63'd0, f}, 64'd1); chk("R10 no stop", {63'd0, s}, 64'd0);
    rd_acc(3, 0, 1'b1, 1'b0, v, f); chk("R10 xlo1 untouched", v, 64'h5);
    wr_acc(12, 1, 1'b0, 64'h0, f, s);
    chk("R10 R11 ri 12/1 no stop", {62'd0, f, s}, 64'd2);
    rd_acc(12, 0, 1'b0, 1'b0, v, f); chk("R10 status untouched", v, 64'hFFFF_FFFF_FA78_FF01);
    rd_acc(5, 0, 1'b0, 1'b1, v, f);
    chk("R10 dst zero no ri", {63'd0, f}, 64'd0); chk("R10 dst zero rdata", v, 64'd0);
    rd_acc(12, 0, 1'b0, 1'b1, v, f); chk("R10 dst zero valid reg", v, 64'd0);
  endtask

  task automatic t_stop;
    logic f, s;
    wr_acc(9, 0, 1'b0, 64'h1, f, s);  chk("R11 counter", {63'd0, s}, 64'd1);
    wr_acc(11, 0, 1'b0, 64'h1, f, s); chk("R11 match", {63'd0, s}, 64'd1);
    wr_acc(16, 3, 1'b0, 64'h1, f, s); chk("R11 opt3", {63'd0, s}, 64'd1);
    wr_acc(31, 0, 1'b0, 64'h1, f, s); chk("R11 scratch", {63'd0, s}, 64'd1);
    wr_acc(14, 0, 1'b0, 64'h1, f, s); chk("R11 eret no stop", {63'd0, s}, 64'd0);
    @(negedge clk);
    valid = 1'b1; wr = 1'b0; rg = 5'd12; sl = 3'd0; #1;
    chk("R11 read no stop", {63'd0, stop}, 64'd0);
    valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_width();
    t_masks();
    t_ctx();
    t_vbase();
    t_cache();
    t_ignored();
    t_reserved();
    t_stop();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule